// File: doc/BRIEF.md
# Set-Associative Cache Read Path with All-Way SECDED Scrubbing

This block is the lookup side of a set-associative cache whose storage cells can be flipped a little at a time by the act of reading them. A lookup reads every way of the addressed set in one access. The tags are compared and every valid way goes through a single-error-correct, double-error-detect check. The requester receives the matching way's corrected word together with hit, way index and an uncorrectable flag, one cycle after the request.

Because every valid way of the set is checked, a disturbed bit in a way that did not match is also found. That way's corrected tag and data are queued for write-back, so the disturbance is repaired before further reads can add a second flip. Write-backs wait in a small queue and are applied only in cycles with no request, so demand traffic is never held up. A demand write cancels any queued write-back aimed at the same line. A separate injection port flips chosen stored bits, which lets a bench create errors in any way.

Top module: `ecc_scrub_cache`

## Requirements
- R1: A read request (req_valid=1, req_wr=0) produces rsp_valid=1 with hit, way, data and uncorrectable status in the following cycle, with no added latency. A write request (req_wr=1) produces no response in the following cycle.
- R2: A read hits when a valid way of the indexed set holds a tag equal to req_tag. rsp_way then gives that way. On a miss, rsp_hit=0 and rsp_data=0.
- R3: A single flipped bit anywhere in the hit way's stored 72-bit data codeword or 13-bit tag codeword is corrected. The returned data equals the written data and rsp_uncorr=0.
- R4: Every valid way of the indexed set is checked on each read. A way with a single-bit error, matching or not, has its corrected tag and data written back. A second flip injected later into the same codeword therefore still reads back corrected.
- R5: Queued write-backs are applied only in cycles where req_valid=0. If a second flip is injected while requests continue back-to-back, the write-back has not yet happened and a read of that line reports an uncorrectable error.
- R6: When the hit way's data codeword holds two flipped bits, the response has rsp_hit=1, rsp_uncorr=1 and rsp_data=0, and the line is invalidated, so the next lookup of that tag misses.
- R7: When a non-matching way's data codeword holds two flipped bits, the requester sees nothing (rsp_uncorr=0, correct data from the hit way), and that way is invalidated, so a later lookup of its tag misses.
- R8: A way whose tag codeword holds two flipped bits never matches and is invalidated. A lookup of its tag misses with rsp_uncorr=0.
- R9: A demand write to a set and way cancels any queued write-back for that line. Data written after such a queued write-back reads back unchanged after the queue drains.
- R10: An injection XORs inj_data_mask into the stored data codeword and inj_tag_mask into the stored tag codeword of the chosen line. When a write to the same line occurs in the same cycle, the masks are applied on top of the newly written value.
- R11: After reset every line is invalid and rsp_valid=0. Every lookup misses until lines are written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 = demand write, 0 = read lookup |
| req_set | input | 4 | Set index |
| req_tag | input | 8 | Tag to compare on reads, tag to store on writes |
| req_way | input | 2 | Way to write (writes only) |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 2 | Way that hit |
| rsp_data | output | 64 | Corrected data of the hit way, 0 otherwise |
| rsp_uncorr | output | 1 | Hit way data was uncorrectable |
| inj_en | input | 1 | Apply injection masks this cycle |
| inj_set | input | 4 | Injection set |
| inj_way | input | 2 | Injection way |
| inj_tag_mask | input | 13 | Bits to flip in the stored tag codeword |
| inj_data_mask | input | 72 | Bits to flip in the stored data codeword |

## Verification
Two pairs of functions can collide in one cycle. The first is a pending write-back against a stream of demand requests. The bench queues a repair, keeps requests running back-to-back while adding a second flip, and expects an uncorrectable hit, because the repair must not have been applied. The second is a demand write landing while a repair for the same line is still queued. The bench writes immediately after the read that queued the repair, lets the queue drain, and expects the new data rather than the stale corrected copy. A same-cycle write and injection is judged the same way: a later extra flip must make the line uncorrectable.

// File: rtl/scrub_pkg.sv
// Shared types and helpers for the scrubbing cache read path.
// Assumes: codewords are Hamming with parity at power-of-two positions
// plus an overall parity bit at position 0.
package scrub_pkg;

    typedef enum logic [1:0] {
        ECC_CLEAN = 2'd0,
        ECC_FIXED = 2'd1,
        ECC_FATAL = 2'd2
    } ecc_stat_e;

    // Number of Hamming check bits needed for k data bits.
    function automatic int secded_chk_bits(input int k);
        int r;
        r = 0;
        for (int i = 1; i < 16; i++) begin
            if (r == 0 && (1 << i) >= k + i + 1) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/secded_enc.sv
// SECDED encoder: places K data bits at non-power-of-two positions,
// computes Hamming parity and an overall parity at bit 0.
// Assumes: K small enough that check bits fit below 16.
module secded_enc
    import scrub_pkg::*;
#(
    parameter int K = 64,
    localparam int R = secded_chk_bits(K),
    localparam int N = K + R
) (
    input  logic [K-1:0] data_i,
    output logic [N:0]   cw_o
);

    // Build the codeword from data and derived parity.
    always_comb begin
        logic [N:0] w;
        int j;
        w = '0;
        j = 0;
        for (int p = 1; p <= N; p++) begin
            if ((p & (p - 1)) != 0) begin
                w[p] = data_i[j];
                j++;
            end
        end
        for (int b = 0; b < R; b++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= N; p++) begin
                if (((p >> b) & 1) == 1) par = par ^ w[p];
            end
            w[1 << b] = par;
        end
        w[0] = ^w[N:1];
        cw_o = w;
    end

endmodule

// File: rtl/secded_dec.sv
// SECDED decoder: reports clean / corrected single / fatal double error,
// returns the repaired codeword and the extracted data bits.
// Assumes: same layout as secded_enc.
module secded_dec
    import scrub_pkg::*;
#(
    parameter int K = 64,
    localparam int R = secded_chk_bits(K),
    localparam int N = K + R
) (
    input  logic [N:0]   cw_i,
    output logic [N:0]   fixed_o,
    output logic [K-1:0] data_o,
    output ecc_stat_e    stat_o
);

    // Syndrome, classification, single-bit repair and data extraction.
    always_comb begin
        logic [R-1:0] syn;
        logic         ovr;
        int           j;
        syn = '0;
        for (int p = 1; p <= N; p++) begin
            if (cw_i[p]) syn = syn ^ p[R-1:0];
        end
        ovr     = ^cw_i;
        fixed_o = cw_i;
        stat_o  = ECC_CLEAN;
        if (ovr) begin
            if (int'(syn) > N) begin
                stat_o = ECC_FATAL;
            end else begin
                stat_o = ECC_FIXED;
                for (int p = 0; p <= N; p++) begin
                    if (int'(syn) == p) fixed_o[p] = ~cw_i[p];
                end
            end
        end else if (syn != '0) begin
            stat_o = ECC_FATAL;
        end
        data_o = '0;
        j = 0;
        for (int p = 1; p <= N; p++) begin
            if ((p & (p - 1)) != 0) begin
                data_o[j] = fixed_o[p];
                j++;
            end
        end
    end

endmodule

// File: rtl/scrub_store.sv
// Cache array model: per set and way a valid bit, tag codeword and data
// codeword. All ways of one set are read combinationally. One write port
// (demand or scrub), a per-way invalidate on the read set, and an XOR
// injection applied last. Assumes writes and invalidates never coincide.
module scrub_store #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TCW   = 13,
    parameter int DCW   = 72,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SET_W-1:0]          rd_set_i,
    output logic [WAYS-1:0]           rd_valid_o,
    output logic [WAYS-1:0][TCW-1:0]  rd_tag_o,
    output logic [WAYS-1:0][DCW-1:0]  rd_data_o,
    input  logic                      wr_en_i,
    input  logic [SET_W-1:0]          wr_set_i,
    input  logic [WAY_W-1:0]          wr_way_i,
    input  logic [TCW-1:0]            wr_tag_i,
    input  logic [DCW-1:0]            wr_data_i,
    input  logic                      wr_mark_valid_i,
    input  logic                      inv_en_i,
    input  logic [WAYS-1:0]           inv_mask_i,
    input  logic                      inj_en_i,
    input  logic [SET_W-1:0]          inj_set_i,
    input  logic [WAY_W-1:0]          inj_way_i,
    input  logic [TCW-1:0]            inj_tag_mask_i,
    input  logic [DCW-1:0]            inj_data_mask_i
);

    logic [WAYS-1:0]          valid_q [SETS];
    logic [WAYS-1:0][TCW-1:0] tag_q   [SETS];
    logic [WAYS-1:0][DCW-1:0] data_q  [SETS];
    logic [WAYS-1:0]          valid_d [SETS];
    logic [WAYS-1:0][TCW-1:0] tag_d   [SETS];
    logic [WAYS-1:0][DCW-1:0] data_d  [SETS];

    // Parallel read of the whole addressed set.
    always_comb begin
        rd_valid_o = valid_q[rd_set_i];
        rd_tag_o   = tag_q[rd_set_i];
        rd_data_o  = data_q[rd_set_i];
    end

    // Next-state of the array: write, then invalidate, then injection XOR.
    always_comb begin
        valid_d = valid_q;
        tag_d   = tag_q;
        data_d  = data_q;
        if (wr_en_i) begin
            tag_d[wr_set_i][wr_way_i]  = wr_tag_i;
            data_d[wr_set_i][wr_way_i] = wr_data_i;
            if (wr_mark_valid_i) valid_d[wr_set_i][wr_way_i] = 1'b1;
        end
        if (inv_en_i) begin
            for (int w = 0; w < WAYS; w++) begin
                if (inv_mask_i[w]) valid_d[rd_set_i][w] = 1'b0;
            end
        end
        if (inj_en_i) begin
            tag_d[inj_set_i][inj_way_i]  = tag_d[inj_set_i][inj_way_i] ^ inj_tag_mask_i;
            data_d[inj_set_i][inj_way_i] = data_d[inj_set_i][inj_way_i] ^ inj_data_mask_i;
        end
    end

    // Array registers; reset clears every line to invalid, all-zero codewords.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                tag_q[s]   <= '0;
                data_q[s]  <= '0;
            end
        end else begin
            valid_q <= valid_d;
            tag_q   <= tag_d;
            data_q  <= data_d;
        end
    end

endmodule

// File: rtl/scrub_fifo.sv
// Scrub write-back queue: up to LANES pushes per cycle (one per way), one
// pop per idle cycle, per-entry cancel by set/way. Pushes that do not fit
// are dropped. Assumes pushes and cancels only occur when busy_i is high.
module scrub_fifo #(
    parameter int DEPTH = 8,
    parameter int LANES = 4,
    parameter int SET_W = 4,
    parameter int WAY_W = 2,
    parameter int PAY_W = 85,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        busy_i,
    input  logic [LANES-1:0]            push_i,
    input  logic [LANES-1:0][SET_W-1:0] push_set_i,
    input  logic [LANES-1:0][WAY_W-1:0] push_way_i,
    input  logic [LANES-1:0][PAY_W-1:0] push_pay_i,
    input  logic                        cancel_i,
    input  logic [SET_W-1:0]            cancel_set_i,
    input  logic [WAY_W-1:0]            cancel_way_i,
    output logic                        drain_we_o,
    output logic [SET_W-1:0]            drain_set_o,
    output logic [WAY_W-1:0]            drain_way_o,
    output logic [PAY_W-1:0]            drain_pay_o
);

    logic [SET_W-1:0] set_q [DEPTH];
    logic [WAY_W-1:0] way_q [DEPTH];
    logic [PAY_W-1:0] pay_q [DEPTH];
    logic [DEPTH-1:0] live_q;
    logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] free_c, n_acc_c;
    logic [LANES-1:0] acc_c;
    logic [LANES-1:0][PTR_W-1:0] off_c;
    logic             pop_c;

    // Admit pushes in lane order while free slots remain.
    always_comb begin
        int k;
        k = 0;
        free_c = CNT_W'(DEPTH) - count_q;
        for (int l = 0; l < LANES; l++) begin
            acc_c[l] = 1'b0;
            off_c[l] = '0;
            if (push_i[l] && k < int'(free_c)) begin
                acc_c[l] = 1'b1;
                off_c[l] = PTR_W'(k);
                k++;
            end
        end
        n_acc_c = CNT_W'(k);
    end

    // Drain only when the request side is idle.
    always_comb begin
        pop_c       = !busy_i && (count_q != '0);
        drain_we_o  = pop_c && live_q[rd_ptr_q];
        drain_set_o = set_q[rd_ptr_q];
        drain_way_o = way_q[rd_ptr_q];
        drain_pay_o = pay_q[rd_ptr_q];
    end

    // Pointers, occupancy and liveness (cancel, pop, push).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
            live_q   <= '0;
        end else begin
            if (cancel_i) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (set_q[i] == cancel_set_i && way_q[i] == cancel_way_i)
                        live_q[i] <= 1'b0;
                end
            end
            if (pop_c) begin
                live_q[rd_ptr_q] <= 1'b0;
                rd_ptr_q         <= rd_ptr_q + 1'b1;
            end
            for (int l = 0; l < LANES; l++) begin
                if (acc_c[l]) live_q[wr_ptr_q + off_c[l]] <= 1'b1;
            end
            wr_ptr_q <= wr_ptr_q + n_acc_c[PTR_W-1:0];
            count_q  <= count_q + n_acc_c - CNT_W'(pop_c);
        end
    end

    // Entry payload storage, guarded by live_q.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (acc_c[l]) begin
                set_q[wr_ptr_q + off_c[l]] <= push_set_i[l];
                way_q[wr_ptr_q + off_c[l]] <= push_way_i[l];
                pay_q[wr_ptr_q + off_c[l]] <= push_pay_i[l];
            end
        end
    end

    // R4: the queue never holds more entries than its depth.
    assert_fifo_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // R5: an idle-cycle drain removes exactly one entry.
    assert_drain_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_c && push_i == '0) |=> count_q == $past(count_q) - 1'b1);

endmodule

// File: rtl/ecc_scrub_cache.sv
// Read path of a set-associative cache that checks SECDED on every valid
// way of the looked-up set, returns the hit way's corrected data one cycle
// later, queues corrected write-backs for any way with a single-bit error,
// and invalidates ways with uncorrectable errors.
// Assumes: tags of valid ways in a set are distinct; lowest way wins otherwise.
module ecc_scrub_cache
    import scrub_pkg::*;
#(
    parameter int WAYS     = 4,
    parameter int SETS     = 16,
    parameter int DATA_W   = 64,
    parameter int TAG_W    = 8,
    parameter int SQ_DEPTH = 8,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int DCW   = DATA_W + secded_chk_bits(DATA_W) + 1,
    localparam int TCW   = TAG_W + secded_chk_bits(TAG_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic [SET_W-1:0]  req_set,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [WAY_W-1:0]  req_way,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_uncorr,
    input  logic              inj_en,
    input  logic [SET_W-1:0]  inj_set,
    input  logic [WAY_W-1:0]  inj_way,
    input  logic [TCW-1:0]    inj_tag_mask,
    input  logic [DCW-1:0]    inj_data_mask
);

    localparam int PAY_W = TCW + DCW;

    logic                      rd_fire, dem_we;
    logic [WAYS-1:0]           way_valid;
    logic [WAYS-1:0][TCW-1:0]  raw_tag;
    logic [WAYS-1:0][DCW-1:0]  raw_data;
    logic [WAYS-1:0][TCW-1:0]  fix_tag;
    logic [WAYS-1:0][DCW-1:0]  fix_data;
    logic [WAYS-1:0][TAG_W-1:0]  dec_tag;
    logic [WAYS-1:0][DATA_W-1:0] dec_data;
    ecc_stat_e                 tag_stat  [WAYS];
    ecc_stat_e                 data_stat [WAYS];
    logic [WAYS-1:0]           match, repair, bad;
    logic                      hit_c;
    logic [WAY_W-1:0]          hit_way_c;
    logic [WAYS-1:0][SET_W-1:0] push_set;
    logic [WAYS-1:0][WAY_W-1:0] push_way;
    logic [WAYS-1:0][PAY_W-1:0] push_pay;
    logic                      drain_we;
    logic [SET_W-1:0]          drain_set;
    logic [WAY_W-1:0]          drain_way;
    logic [PAY_W-1:0]          drain_pay;
    logic [TCW-1:0]            enc_tag;
    logic [DCW-1:0]            enc_data;
    logic                      st_we;
    logic [SET_W-1:0]          st_set;
    logic [WAY_W-1:0]          st_way;
    logic [TCW-1:0]            st_tag;
    logic [DCW-1:0]            st_data;

    // Request decode.
    always_comb begin
        rd_fire = req_valid && !req_wr;
        dem_we  = req_valid && req_wr;
    end

    // Encoders for demand writes.
    secded_enc #(.K(TAG_W))  u_enc_tag  (.data_i(req_tag),   .cw_o(enc_tag));
    secded_enc #(.K(DATA_W)) u_enc_data (.data_i(req_wdata), .cw_o(enc_data));

    // Per-way checkers and per-way classification.
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        secded_dec #(.K(TAG_W)) u_dec_tag (
            .cw_i(raw_tag[g]), .fixed_o(fix_tag[g]),
            .data_o(dec_tag[g]), .stat_o(tag_stat[g]));
        secded_dec #(.K(DATA_W)) u_dec_data (
            .cw_i(raw_data[g]), .fixed_o(fix_data[g]),
            .data_o(dec_data[g]), .stat_o(data_stat[g]));

        // Match, repair-needed and invalidate flags for this way.
        always_comb begin
            match[g]  = way_valid[g] && tag_stat[g] != ECC_FATAL && dec_tag[g] == req_tag;
            bad[g]    = way_valid[g] && (tag_stat[g] == ECC_FATAL || data_stat[g] == ECC_FATAL);
            repair[g] = way_valid[g] && !bad[g]
                        && (tag_stat[g] == ECC_FIXED || data_stat[g] == ECC_FIXED);
            push_set[g] = req_set;
            push_way[g] = WAY_W'(g);
            push_pay[g] = {fix_tag[g], fix_data[g]};
        end
    end

    // Hit select: lowest matching way.
    always_comb begin
        hit_c     = 1'b0;
        hit_way_c = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_c     = 1'b1;
                hit_way_c = WAY_W'(w);
            end
        end
    end

    // Array write port: demand write has the request slot, scrub uses idle slots.
    always_comb begin
        st_we   = dem_we || drain_we;
        st_set  = dem_we ? req_set  : drain_set;
        st_way  = dem_we ? req_way  : drain_way;
        st_tag  = dem_we ? enc_tag  : drain_pay[PAY_W-1 -: TCW];
        st_data = dem_we ? enc_data : drain_pay[DCW-1:0];
    end

    scrub_store #(.SETS(SETS), .WAYS(WAYS), .TCW(TCW), .DCW(DCW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_set_i(req_set), .rd_valid_o(way_valid),
        .rd_tag_o(raw_tag), .rd_data_o(raw_data),
        .wr_en_i(st_we), .wr_set_i(st_set), .wr_way_i(st_way),
        .wr_tag_i(st_tag), .wr_data_i(st_data), .wr_mark_valid_i(dem_we),
        .inv_en_i(rd_fire), .inv_mask_i(bad),
        .inj_en_i(inj_en), .inj_set_i(inj_set), .inj_way_i(inj_way),
        .inj_tag_mask_i(inj_tag_mask), .inj_data_mask_i(inj_data_mask));

    scrub_fifo #(.DEPTH(SQ_DEPTH), .LANES(WAYS), .SET_W(SET_W),
                 .WAY_W(WAY_W), .PAY_W(PAY_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .busy_i(req_valid),
        .push_i(rd_fire ? repair : '0),
        .push_set_i(push_set), .push_way_i(push_way), .push_pay_i(push_pay),
        .cancel_i(dem_we), .cancel_set_i(req_set), .cancel_way_i(req_way),
        .drain_we_o(drain_we), .drain_set_o(drain_set),
        .drain_way_o(drain_way), .drain_pay_o(drain_pay));

    // Response register: one cycle after the read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_way    <= '0;
            rsp_data   <= '0;
            rsp_uncorr <= 1'b0;
        end else begin
            rsp_valid  <= rd_fire;
            rsp_hit    <= rd_fire && hit_c;
            rsp_way    <= hit_c ? hit_way_c : '0;
            rsp_uncorr <= rd_fire && hit_c && data_stat[hit_way_c] == ECC_FATAL;
            rsp_data   <= (rd_fire && hit_c && data_stat[hit_way_c] != ECC_FATAL)
                          ? dec_data[hit_way_c] : '0;
        end
    end

    // R1: every read is answered in the next cycle.
    assert_rsp_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_wr) |=> rsp_valid);

    // R1: writes and idle cycles produce no response.
    assert_no_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_wr) |=> !rsp_valid);

    // R6: an uncorrectable report always belongs to a hit with zeroed data.
    assert_uncorr_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_uncorr) |-> (rsp_hit && rsp_data == '0));

    // R5: the queue never writes the array while a request is present.
    assert_scrub_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drain_we |-> !req_valid);

endmodule

// File: tb/ecc_scrub_cache_tb_top.sv
`timescale 1ns/1ps
module ecc_scrub_cache_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_wr;
    logic [3:0]  req_set;
    logic [7:0]  req_tag;
    logic [1:0]  req_way;
    logic [63:0] req_wdata;
    logic        rsp_valid, rsp_hit, rsp_uncorr;
    logic [1:0]  rsp_way;
    logic [63:0] rsp_data;
    logic        inj_en;
    logic [3:0]  inj_set;
    logic [1:0]  inj_way;
    logic [12:0] inj_tag_mask;
    logic [71:0] inj_data_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ecc_scrub_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_wr(req_wr), .req_set(req_set),
        .req_tag(req_tag), .req_way(req_way), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_data(rsp_data), .rsp_uncorr(rsp_uncorr),
        .inj_en(inj_en), .inj_set(inj_set), .inj_way(inj_way),
        .inj_tag_mask(inj_tag_mask), .inj_data_mask(inj_data_mask));

    function automatic logic [63:0] pat(input int s, input int w);
        return {8'(s), 8'(w), 48'h5A3C_0F96_C3A5} ^ (64'(s * 7 + w * 3 + 1) << 17);
    endfunction

    function automatic logic [7:0] tagv(input int s, input int w);
        return {2'(w), 4'(s), 2'b10};
    endfunction

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One request cycle with optional injection; result visible on return.
    task automatic cyc(input logic v, input logic wr, input int s, input logic [7:0] t,
                       input int w, input logic [63:0] d, input logic ie, input int is,
                       input int iw, input logic [12:0] tm, input logic [71:0] dm);
        req_valid = v; req_wr = wr; req_set = 4'(s); req_tag = t;
        req_way = 2'(w); req_wdata = d;
        inj_en = ie; inj_set = 4'(is); inj_way = 2'(iw);
        inj_tag_mask = tm; inj_data_mask = dm;
        @(negedge clk);
        req_valid = 1'b0; req_wr = 1'b0; inj_en = 1'b0;
        inj_tag_mask = '0; inj_data_mask = '0;
    endtask

    task automatic wr(input int s, input int w, input logic [7:0] t, input logic [63:0] d);
        cyc(1, 1, s, t, w, d, 0, 0, 0, '0, '0);
    endtask

    task automatic rd(input int s, input logic [7:0] t);
        cyc(1, 0, s, t, 0, '0, 0, 0, 0, '0, '0);
    endtask

    task automatic inj(input int s, input int w, input logic [12:0] tm, input logic [71:0] dm);
        cyc(0, 0, 0, '0, 0, '0, 1, s, w, tm, dm);
    endtask

    task automatic expect_hit(input string req, input int w, input logic [63:0] d);
        check(req, {71'b0, rsp_valid}, 72'd1);
        check(req, {71'b0, rsp_hit}, 72'd1);
        check(req, {70'b0, rsp_way}, 72'(w));
        check(req, {8'b0, rsp_data}, {8'b0, d});
        check(req, {71'b0, rsp_uncorr}, 72'd0);
    endtask

    task automatic expect_miss(input string req);
        check(req, {71'b0, rsp_valid}, 72'd1);
        check(req, {71'b0, rsp_hit}, 72'd0);
        check(req, {71'b0, rsp_uncorr}, 72'd0);
        check(req, {8'b0, rsp_data}, 72'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_wr = 1'b0; req_set = '0; req_tag = '0;
        req_way = '0; req_wdata = '0; inj_en = 1'b0; inj_set = '0; inj_way = '0;
        inj_tag_mask = '0; inj_data_mask = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R11: reset state
        check("R11 rsp_valid after reset", {71'b0, rsp_valid}, 72'd0);
        for (int s = 0; s < 16; s++) begin
            rd(s, tagv(s, 1));
            expect_miss("R11 empty lookup");
        end

        // Fill every line; R1 no response for writes.
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++) begin
                wr(s, w, tagv(s, w), pat(s, w));
                check("R1 no rsp on write", {71'b0, rsp_valid}, 72'd0);
            end

        // R1, R2: every line hits in its way, foreign tag misses.
        for (int s = 0; s < 16; s++) begin
            for (int w = 0; w < 4; w++) begin
                rd(s, tagv(s, w));
                expect_hit("R1 R2 clean hit", w, pat(s, w));
            end
            rd(s, 8'hFF);
            expect_miss("R2 miss");
        end

        // R3: every data codeword bit position, hit way.
        for (int b = 0; b < 72; b++) begin
            inj(b % 16, b % 4, '0, 72'(1) << b);
            rd(b % 16, tagv(b % 16, b % 4));
            expect_hit("R3 data bit", b % 4, pat(b % 16, b % 4));
            idle(2);
        end

        // R3: every tag codeword bit position, hit way.
        for (int b = 0; b < 13; b++) begin
            inj(b, 3 - (b % 4), 13'(1) << b, '0);
            rd(b, tagv(b, 3 - (b % 4)));
            expect_hit("R3 tag bit", 3 - (b % 4), pat(b, 3 - (b % 4)));
            idle(2);
        end

        // R4: errors in non-matching ways are repaired.
        for (int w = 0; w < 4; w++) begin
            inj(5, w, '0, 72'(1) << (7 + w));
            rd(5, tagv(5, (w + 1) % 4));
            expect_hit("R4 other way hit", (w + 1) % 4, pat(5, (w + 1) % 4));
            idle(3);
            inj(5, w, '0, 72'(1) << (40 + w));
            rd(5, tagv(5, w));
            expect_hit("R4 repaired non-matching data", w, pat(5, w));
            idle(2);
        end
        inj(6, 2, 13'(1) << 3, '0);
        rd(6, tagv(6, 0));
        expect_hit("R4 other way hit tag", 0, pat(6, 0));
        idle(3);
        inj(6, 2, 13'(1) << 9, '0);
        rd(6, tagv(6, 2));
        expect_hit("R4 repaired non-matching tag", 2, pat(6, 2));
        idle(2);

        // R5 + R6: back-to-back requests block the repair; second flip is fatal.
        inj(7, 3, '0, 72'(1) << 11);
        rd(7, tagv(7, 0));
        expect_hit("R5 first read", 0, pat(7, 0));
        cyc(1, 0, 7, tagv(7, 0), 0, '0, 1, 7, 3, '0, 72'(1) << 20);
        expect_hit("R5 second read", 0, pat(7, 0));
        rd(7, tagv(7, 3));
        check("R5 R6 uncorr", {71'b0, rsp_uncorr}, 72'd1);
        check("R6 hit on uncorr", {71'b0, rsp_hit}, 72'd1);
        check("R6 data zero", {8'b0, rsp_data}, 72'd0);
        rd(7, tagv(7, 3));
        expect_miss("R6 invalidated");
        idle(4);
        rd(7, tagv(7, 3));
        expect_miss("R6 stays invalid after drain");
        wr(7, 3, tagv(7, 3), pat(7, 3));

        // R7: fatal data in a non-matching way is silent but invalidates.
        inj(8, 1, '0, (72'(1) << 2) | (72'(1) << 30));
        rd(8, tagv(8, 0));
        expect_hit("R7 silent", 0, pat(8, 0));
        rd(8, tagv(8, 1));
        expect_miss("R7 invalidated");
        wr(8, 1, tagv(8, 1), pat(8, 1));

        // R8: fatal tag never matches.
        inj(9, 2, (13'(1) << 1) | (13'(1) << 5), '0);
        rd(9, tagv(9, 2));
        expect_miss("R8 fatal tag miss");
        rd(9, tagv(9, 2));
        expect_miss("R8 stays invalid");
        wr(9, 2, tagv(9, 2), pat(9, 2));

        // R9: demand write cancels a queued repair.
        inj(10, 1, '0, 72'(1) << 15);
        rd(10, tagv(10, 1));
        expect_hit("R9 queued repair", 1, pat(10, 1));
        wr(10, 1, tagv(10, 1), ~pat(10, 1));
        idle(4);
        rd(10, tagv(10, 1));
        expect_hit("R9 new data kept", 1, ~pat(10, 1));

        // R10: injection lands on top of a same-cycle write.
        cyc(1, 1, 11, tagv(11, 0), 0, 64'h0123_4567_89AB_CDEF, 1, 11, 0, '0, 72'(1) << 4);
        inj(11, 0, '0, 72'(1) << 50);
        rd(11, tagv(11, 0));
        check("R10 inj over write", {71'b0, rsp_uncorr}, 72'd1);
        wr(11, 0, tagv(11, 0), pat(11, 0));
        rd(11, tagv(11, 0));
        expect_hit("R10 restored", 0, pat(11, 0));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule